// File: doc/BRIEF.md
# Eight-Pixel Colour Compare Unit

This block tests the eight pixels stored at one byte address of a three-plane video memory against a bank of eight programmable colour codes. It returns an 8-bit match status with one bit per pixel. After a trigger, it fetches the blue, red and green plane bytes at the requested address one after another. For each pixel it forms a 3-bit colour code and compares that code with every compare register that is marked valid. Planes that the plane-disable register switches off take no part in the comparison.

The host sets up the eight compare registers and the plane-disable register through a simple write port. It then pulses `start` with a byte address and watches `busy`. When `busy` falls, `status` holds the new match byte. That byte stays unchanged until the next compare finishes. A raster stage downstream can use it as a per-pixel write mask.

The control is a five-state machine:

- IDLE waits for `start`.
- FETCH_B issues the blue read.
- FETCH_R issues the red read and captures the blue byte.
- FETCH_G issues the green read and captures the red byte.
- RESOLVE uses the green byte straight from the read port and commits the status.

The transitions run IDLE→FETCH_B (when `start` is high), FETCH_B→FETCH_R, FETCH_R→FETCH_G, FETCH_G→RESOLVE and RESOLVE→IDLE. The last four are unconditional.

Top module: `pixel_cmp_unit`

## Requirements
- R1: Reset clears `status` to 0x00 and `busy` to 0. It sets all eight compare registers to 0x80, so a compare run before any register write reports 0x00.
- R2: A `start` accepted in IDLE is followed by exactly three reads, one per cycle, in the order plane 0 (blue), plane 1 (red), plane 2 (green). Each read carries the latched address in `mem_rd_addr[ADDR_W-1:0]` and the plane number in the top two bits. `busy` is high for exactly four cycles. Read data is returned one cycle after `mem_rd_en`.
- R3: A pixel's colour code is {green, red, blue}: blue is bit 0, red is bit 1 and green is bit 2.
- R4: Pixel k is bit k of each plane byte, and its result is status bit k. The leftmost pixel, bit 7, lands in status bit 7.
- R5: A compare register with bit 7 set is invalid and never matches.
- R6: The comparison mask is the inverse of plane-disable bits [2:0]; disable bits 7..3 have no effect. The pixel code and the register's low three bits are both ANDed with the mask before the equality test.
- R7: A status bit is 1 when at least one valid compare register matches that pixel.
- R8: `status` changes only at the end of RESOLVE and otherwise holds. A `start` while `busy` is high is ignored.
- R9: Register write addresses 0 to 7 select compare registers 0 to 7, address 8 selects plane-disable, and addresses 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write address |
| reg_wdata | input | 8 | Register write data |
| start | input | 1 | Compare trigger |
| start_addr | input | ADDR_W | Byte address to compare |
| mem_rd_en | output | 1 | Plane read request |
| mem_rd_addr | output | ADDR_W+2 | {plane, byte address} |
| mem_rd_data | input | 8 | Read data, one cycle after request |
| busy | output | 1 | Compare in progress |
| status | output | 8 | Per-pixel match status |

## Verification
Two situations are the hardest to reach from the ports.

The first is a second trigger arriving while a compare is already in flight. The bench raises `start` again with a different address during the fetch cycles. It then checks that exactly three reads were made, all at the first address, and that the status matches the first address's pixels.

The second is the interplay of invalid registers with masking. With every plane disabled, any valid register matches every pixel while invalid ones still match nothing. Reaching this requires writing the disable register, compare registers with bit 7 set, and plane data together, in one sequence.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_B,
        ST_FETCH_R,
        ST_FETCH_G,
        ST_RESOLVE
    } pcu_state_e;

    localparam logic [1:0] PLANE_B    = 2'd0;
    localparam logic [1:0] PLANE_R    = 2'd1;
    localparam logic [1:0] PLANE_G    = 2'd2;
    localparam int         CODE_W     = 3;
    localparam int         BYTE_W     = 8;
    localparam int         REG_AW     = 4;
    localparam logic [7:0] CMP_RESET  = 8'h80;
endpackage

// File: rtl/pcu_regfile.sv
module pcu_regfile
    import pcu_pkg::*;
#(
    parameter int NUM_CMP = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [REG_AW-1:0]               waddr,
    input  logic [BYTE_W-1:0]               wdata,
    output logic [NUM_CMP-1:0][BYTE_W-1:0]  cmp_regs,
    output logic [BYTE_W-1:0]               dis_reg
);
    localparam logic [REG_AW-1:0] DIS_ADDR = REG_AW'(NUM_CMP);

    for (genvar j = 0; j < NUM_CMP; j++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp_regs[j] <= CMP_RESET;
            else if (wr && waddr == REG_AW'(j))
                cmp_regs[j] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            dis_reg <= '0;
        else if (wr && waddr == DIS_ADDR)
            dis_reg <= wdata;
    end
endmodule

// File: rtl/pcu_matcher.sv
module pcu_matcher
    import pcu_pkg::*;
#(
    parameter int NUM_PIX = 8,
    parameter int NUM_CMP = 8
) (
    input  logic [NUM_PIX-1:0]              blue,
    input  logic [NUM_PIX-1:0]              red,
    input  logic [NUM_PIX-1:0]              green,
    input  logic [NUM_CMP-1:0][BYTE_W-1:0]  cmp_regs,
    input  logic [BYTE_W-1:0]               dis_reg,
    output logic [NUM_PIX-1:0]              match
);
    logic [CODE_W-1:0] mask;
    assign mask = ~dis_reg[CODE_W-1:0];

    for (genvar p = 0; p < NUM_PIX; p++) begin : g_pix
        logic [CODE_W-1:0] code;
        assign code = {green[p], red[p], blue[p]} & mask;
        always_comb begin
            match[p] = 1'b0;
            for (int j = 0; j < NUM_CMP; j++) begin
                if (!cmp_regs[j][BYTE_W-1] &&
                    ((cmp_regs[j][CODE_W-1:0] & mask) == code))
                    match[p] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcu_sequencer.sv
module pcu_sequencer
    import pcu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       busy,
    output logic       rd_en,
    output logic [1:0] plane,
    output logic       cap_blue,
    output logic       cap_red,
    output logic       commit
);
    pcu_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_FETCH_B;
            ST_FETCH_B: state_d = ST_FETCH_R;
            ST_FETCH_R: state_d = ST_FETCH_G;
            ST_FETCH_G: state_d = ST_RESOLVE;
            ST_RESOLVE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        rd_en    = 1'b0;
        plane    = PLANE_B;
        cap_blue = 1'b0;
        cap_red  = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_FETCH_B: rd_en = 1'b1;
            ST_FETCH_R: begin
                rd_en    = 1'b1;
                plane    = PLANE_R;
                cap_blue = 1'b1;
            end
            ST_FETCH_G: begin
                rd_en   = 1'b1;
                plane   = PLANE_G;
                cap_red = 1'b1;
            end
            ST_RESOLVE: commit = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/pixel_cmp_unit.sv
module pixel_cmp_unit
    import pcu_pkg::*;
#(
    parameter int ADDR_W  = 14,
    parameter int NUM_CMP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              mem_rd_en,
    output logic [ADDR_W+1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              busy,
    output logic [7:0]        status
);
    localparam int NUM_PIX = BYTE_W;

    logic [NUM_CMP-1:0][BYTE_W-1:0] cmp_regs;
    logic [BYTE_W-1:0]              dis_reg;
    logic [ADDR_W-1:0]              addr_q;
    logic [NUM_PIX-1:0]             blue_q, red_q, match;
    logic [NUM_PIX-1:0]             status_q;
    logic [1:0]                     plane;
    logic                           cap_blue, cap_red, commit;

    pcu_regfile #(.NUM_CMP(NUM_CMP)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .waddr    (reg_addr),
        .wdata    (reg_wdata),
        .cmp_regs (cmp_regs),
        .dis_reg  (dis_reg)
    );

    pcu_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .rd_en    (mem_rd_en),
        .plane    (plane),
        .cap_blue (cap_blue),
        .cap_red  (cap_red),
        .commit   (commit)
    );

    pcu_matcher #(.NUM_PIX(NUM_PIX), .NUM_CMP(NUM_CMP)) u_match (
        .blue     (blue_q),
        .red      (red_q),
        .green    (mem_rd_data),
        .cmp_regs (cmp_regs),
        .dis_reg  (dis_reg),
        .match    (match)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            blue_q   <= '0;
            red_q    <= '0;
            status_q <= '0;
        end else begin
            if (start && !busy) addr_q   <= start_addr;
            if (cap_blue)       blue_q   <= mem_rd_data;
            if (cap_red)        red_q    <= mem_rd_data;
            if (commit)         status_q <= match;
        end
    end

    assign mem_rd_addr = {plane, addr_q};
    assign status      = status_q;
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              mem_rd_en,
    input logic [ADDR_W+1:0] mem_rd_addr,
    input logic [7:0]        status
);
    logic [1:0] pl;
    assign pl = mem_rd_addr[ADDR_W+1:ADDR_W];

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (status == 8'h00 && !busy));

    p_first_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_rd_en && pl == 2'd0));

    p_blue_then_red_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && pl == 2'd0) |=> (mem_rd_en && pl == 2'd1 && $stable(mem_rd_addr[ADDR_W-1:0])));

    p_red_then_green_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && pl == 2'd1) |=> (mem_rd_en && pl == 2'd2 && $stable(mem_rd_addr[ADDR_W-1:0])));

    p_green_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && pl == 2'd2) |=> (!mem_rd_en && busy));

    p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!busy) |-> $stable(status));
endmodule

bind pixel_cmp_unit pcu_checker #(.ADDR_W(ADDR_W)) u_pcu_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .status      (status)
);

// File: tb/tb_pixel_cmp_unit.sv
`timescale 1ns/1ps
module tb_pixel_cmp_unit;
    localparam int ADDR_W = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [3:0]        reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              mem_rd_en;
    logic [ADDR_W+1:0] mem_rd_addr;
    logic [7:0]        mem_rd_data = '0;
    logic              busy;
    logic [7:0]        status;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench memory: three plane bytes valid only at tb_addr
    logic [7:0]        plane_mem [3];
    logic [ADDR_W-1:0] tb_addr = '0;
    int                rd_cnt = 0;
    logic [1:0]        rd_log [8];
    logic [ADDR_W-1:0] rd_alog [8];

    always #2.5 clk = ~clk;

    pixel_cmp_unit #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .start(start), .start_addr(start_addr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .busy(busy), .status(status)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            logic [1:0] p;
            p = mem_rd_addr[ADDR_W+1:ADDR_W];
            mem_rd_data <= (mem_rd_addr[ADDR_W-1:0] == tb_addr && p != 2'd3) ? plane_mem[p] : 8'h00;
            if (rd_cnt < 8) begin
                rd_log[rd_cnt]  = p;
                rd_alog[rd_cnt] = mem_rd_addr[ADDR_W-1:0];
            end
            rd_cnt = rd_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_planes(input logic [7:0] b, input logic [7:0] r, input logic [7:0] g);
        plane_mem[0] = b; plane_mem[1] = r; plane_mem[2] = g;
    endtask

    // pulse start, wait for completion, return busy cycle count
    task automatic run_cmp(input logic [ADDR_W-1:0] a, output int cyc);
        @(negedge clk);
        rd_cnt = 0;
        start = 1'b1; start_addr = a;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < 20) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    // {blue, red, green, disable, expected}; compare regs 0=0x05, 1=0x02, rest invalid
    localparam logic [39:0] VEC [10] = '{
        {8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF},
        {8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF},
        {8'hF0, 8'h0F, 8'hF0, 8'h00, 8'hFF},
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        {8'hAA, 8'h00, 8'hA0, 8'h00, 8'hA0},
        {8'hAA, 8'h00, 8'h00, 8'h04, 8'hAA},
        {8'h00, 8'h00, 8'h00, 8'h07, 8'hFF},
        {8'hFF, 8'h00, 8'hFF, 8'hF8, 8'hFF},
        {8'h80, 8'h00, 8'h80, 8'h00, 8'h80},
        {8'h01, 8'h00, 8'h01, 8'h00, 8'h01}
    };

    initial begin
        #20000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cyc;
        set_planes(8'h00, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 status", status, 8'h00);
        check("R1 busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R5: reset regs are invalid, black pixels must not match
        tb_addr = 14'h0123;
        run_cmp(14'h0123, cyc);
        check("R1 invalid after reset", status, 8'h00);
        // R2: busy length, read order and address
        check("R2 busy cycles", cyc, 4);
        check("R2 read count", rd_cnt, 3);
        check("R2 order", {rd_log[0], rd_log[1], rd_log[2]}, {2'd0, 2'd1, 2'd2});
        check("R2 address", rd_alog[2], 14'h0123);

        // table walk: R3 R4 R6 R7
        wr_reg(4'd0, 8'h05);
        wr_reg(4'd1, 8'h02);
        for (int i = 0; i < 10; i++) begin
            wr_reg(4'd8, VEC[i][15:8]);
            set_planes(VEC[i][39:32], VEC[i][31:24], VEC[i][23:16]);
            tb_addr = 14'(i * 37);
            run_cmp(14'(i * 37), cyc);
            check($sformatf("R3 R4 R6 R7 vec%0d", i), status, VEC[i][7:0]);
        end

        // R5: bit 7 set makes a register invalid even with matching code
        wr_reg(4'd8, 8'h00);
        wr_reg(4'd0, 8'h80);
        wr_reg(4'd1, 8'h80);
        wr_reg(4'd2, 8'h83);
        set_planes(8'hFF, 8'hFF, 8'h00);
        run_cmp(tb_addr, cyc);
        check("R5 invalid reg", status, 8'h00);
        // R5: clearing bit 7 makes it match
        wr_reg(4'd2, 8'h03);
        run_cmp(tb_addr, cyc);
        check("R5 valid reg", status, 8'hFF);

        // R9: address 7 is a compare reg, address 12 writes nothing
        wr_reg(4'd2, 8'h80);
        wr_reg(4'd12, 8'h03);
        run_cmp(tb_addr, cyc);
        check("R9 unmapped address", status, 8'h00);
        wr_reg(4'd7, 8'h03);
        run_cmp(tb_addr, cyc);
        check("R9 reg7", status, 8'hFF);

        // R8: status holds while idle after register and data changes
        wr_reg(4'd7, 8'h80);
        set_planes(8'h00, 8'h00, 8'h00);
        repeat (5) @(negedge clk);
        check("R8 hold", status, 8'hFF);

        // R8: start during busy is ignored
        wr_reg(4'd7, 8'h03);
        tb_addr = 14'h0200;
        set_planes(8'h0F, 8'h0F, 8'h00);
        @(negedge clk);
        rd_cnt = 0;
        start = 1'b1; start_addr = 14'h0200;
        @(negedge clk);
        start_addr = 14'h0300;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < 20) begin cyc++; @(negedge clk); end
        check("R8 status first addr", status, 8'h0F);
        check("R8 read count", rd_cnt, 3);
        check("R8 read address", rd_alog[2], 14'h0200);
        repeat (3) @(negedge clk);
        check("R8 no restart", busy, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule